// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block lets a processor run clause-22 management frames to an external Ethernet PHY through two 32-bit registers. The gateway register holds the whole command and its status. Software writes the command with the busy bit set, and the block then sends one read or write frame on MDC/MDIO. Software polls the busy bit until the hardware clears it. After a read, the PHY's 16 data bits are found in the gateway's low half-word. Bit 31 is a lock that belongs to software alone. An agent sets the lock with its command and releases it by writing an all-zero word, which never starts a frame.

The configuration register sets the MDC half-period as a count of core cycles. It also sets how many core cycles before the MDC-raising core edge MDIO is sampled, and how many core cycles after that edge a new output bit is launched. It also stores a 2-bit mode field, a 3.3 V select bit and a full-drive bit for the pad logic around the block. The pad itself is outside the block: MDIO appears as separate out, output-enable and in signals.

Top module: `mgmt_mdio_gw`

## Requirements
- R1: After reset the gateway reads 0, MDC and output-enable are low, and the configuration register reads its default. The configuration fields are: mode in bits 1:0 (default 1), 3.3 V select in bit 2 (default 1), full-drive in bit 3 (default 1), half-period count in bits 11:4 (default (400 × 100 / 1000) / 2 − 1 = 19), input offset in bits 15:12 (default 6) and output offset in bits 19:16 (default 13). Bits 31:20 read 0, so the default word is 0x000D613D.
- R2: The gateway fields are data in bits 15:0, PHY address in bits 20:16, register address in bits 25:21, opcode in bits 27:26, busy in bit 30 and lock in bit 31. A write with busy set while idle sends 64 bits, MSB first, one per MDC rising edge: 32 ones, 01, the opcode, the PHY address, the register address, 10, and then the 16 data bits.
- R3: For opcode 10 (read), output-enable is high for the first 46 bit times and low from the turnaround onward. The 16 bits sampled in the data phase, MSB first, replace gateway bits 15:0. All other gateway bits keep the values that were written, except busy.
- R4: Busy reads 1 from the edge that accepts a command until the frame ends after exactly 64 MDC periods. While busy is 0, MDC stays low and makes no edges.
- R5: An all-zero gateway write while idle starts no frame and clears the whole gateway, including the lock.
- R6: An all-zero gateway write while busy aborts the frame. Busy and output-enable are 0 after that edge, MDC is low one edge later, and no further MDC edges follow.
- R7: While busy, any nonzero gateway write and any configuration write have no effect.
- R8: A nonzero gateway write with bit 30 clear, made while idle, is stored as written and starts no frame.
- R9: With half-period count H, MDC stays high for H+1 core cycles and low for H+1 core cycles.
- R10: With input offset N, MDIO is sampled N core cycles before the core edge that raises MDC. Data that changes k edges after MDC falls is captured when k ≤ H − N; otherwise the previous value is captured.
- R11: With output offset M, each new MDIO output bit appears M core cycles after the edge that raises MDC.
- R12: An input offset larger than H acts as H, and an output offset larger than H+1 acts as H+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 gateway, 1 configuration |
| reg_wdata | input | 32 | Register write data |
| gw_rdata | output | 32 | Gateway register contents |
| cfg_rdata | output | 32 | Configuration register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
A wrong bit index or a lost shift shows up as a wrong bit in the captured MDIO frame, within the 64 MDC edges of that same frame. A slot counter that counts wrongly changes the measured MDC high and low times, or the distance from the MDC rise to the launch, in the first bit period. A wrong sampling point shows as read data shifted by one bit, and that error is visible in the gateway as soon as busy drops. A busy flag or lock bit in the wrong state shows in the very next gateway read, as a frame that never ends, an extra frame, or a command that was ignored.

// File: rtl/mgw_pkg.sv
package mgw_pkg;

    localparam int FRAME_BITS = 64;
    localparam logic [5:0] LAST_IDX = 6'd63;
    localparam logic [5:0] TA_IDX   = 6'd46;
    localparam logic [5:0] DATA_IDX = 6'd48;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    // gateway word, MSB first
    typedef struct packed {
        logic        lock;
        logic        busy;
        logic        spare;
        logic        st;
        logic [1:0]  op;
        logic [4:0]  reg_a;
        logic [4:0]  phy;
        logic [15:0] ad;
    } gw_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input gw_t g);
        return {32'hFFFF_FFFF, 2'b01, g.op, g.phy, g.reg_a, 2'b10, g.ad};
    endfunction

endpackage

// File: rtl/mgw_slot_timer.sv
module mgw_slot_timer #(
    parameter int HALF_W = 8,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [OFF_W-1:0]  out_off,
    output logic              mdc,
    output logic              launch,
    output logic              sample,
    output logic              slot_end
);
    localparam int CW = HALF_W + 1;

    logic [CW-1:0] t, t_nxt, half_x, top_t, in_x, out_x, in_eff, out_eff, in_pt, out_pt;

    always_comb begin
        half_x  = {1'b0, half};
        top_t   = {half, 1'b1};
        in_x    = CW'(in_off);
        out_x   = CW'(out_off);
        in_eff  = (in_x > half_x) ? half_x : in_x;
        out_eff = (out_x > half_x + CW'(1)) ? half_x + CW'(1) : out_x;
        in_pt   = half_x - in_eff;
        out_pt  = half_x + out_eff;
        t_nxt   = (t == top_t) ? '0 : t + CW'(1);
    end

    assign launch   = run && (t == out_pt);
    assign sample   = run && (t == in_pt);
    assign slot_end = run && (t == top_t);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            t   <= '0;
            mdc <= 1'b0;
        end else begin
            t   <= t_nxt;
            mdc <= (t_nxt > half_x);
        end
    end

    // R4: no clock activity while idle
    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !mdc);

endmodule

// File: rtl/mgw_frame_engine.sv
module mgw_frame_engine
    import mgw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  is_read,
    input  logic                  run,
    input  logic                  stop,
    input  logic                  launch,
    input  logic                  sample,
    input  logic                  slot_end,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rdata
);
    logic [FRAME_BITS-1:0] sh;
    logic [5:0]            idx;
    logic                  rd_q;

    assign done = run && slot_end && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            idx     <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            rdata   <= '0;
        end else if (start) begin
            sh      <= frame_in;
            mdio_o  <= frame_in[FRAME_BITS-1];
            mdio_oe <= 1'b1;
            idx     <= '0;
            rd_q    <= is_read;
        end else if (stop || done) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (run) begin
            if (launch && idx != LAST_IDX) begin
                sh     <= sh << 1;
                mdio_o <= sh[FRAME_BITS-2];
                if (rd_q && (idx + 6'd1 >= TA_IDX))
                    mdio_oe <= 1'b0;
            end
            if (sample && rd_q && idx >= DATA_IDX)
                rdata <= {rdata[14:0], mdio_i};
            if (slot_end)
                idx <= idx + 6'd1;
        end
    end

    // R3: bus released by the master during the read data phase
    a_r3_oe_released_on_read: assert property (@(posedge clk) disable iff (rst)
        (run && rd_q && idx > TA_IDX) |-> !mdio_oe);

    // R6: pad never driven while idle
    a_r6_oe_idle: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !mdio_oe);

endmodule

// File: rtl/mgmt_mdio_gw.sv
module mgmt_mdio_gw
    import mgw_pkg::*;
#(
    parameter int MDC_PERIOD_NS = 400,
    parameter int CORE_MHZ      = 100,
    parameter int HALF_W        = 8,
    parameter int OFF_W         = 4,
    parameter int IN_SAMP_DEF   = 6,
    parameter int OUT_SAMP_DEF  = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] gw_rdata,
    output logic [31:0] cfg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam int HALF_DEF = ((MDC_PERIOD_NS * CORE_MHZ / 1000) / 2) - 1;
    localparam int MODE_LSB = 0;
    localparam int V33_BIT  = 2;
    localparam int DRV_BIT  = 3;
    localparam int HALF_LSB = 4;
    localparam int IN_LSB   = HALF_LSB + HALF_W;
    localparam int OUT_LSB  = IN_LSB + OFF_W;
    localparam int CFG_BITS = OUT_LSB + OFF_W;
    localparam logic [31:0] CFG_MASK = (32'd1 << CFG_BITS) - 32'd1;
    localparam logic [31:0] CFG_RST  = (32'd1 << MODE_LSB) | (32'd1 << V33_BIT) |
                                       (32'd1 << DRV_BIT) |
                                       (32'(HALF_DEF) << HALF_LSB) |
                                       (32'(IN_SAMP_DEF) << IN_LSB) |
                                       (32'(OUT_SAMP_DEF) << OUT_LSB);

    gw_t         gw_q;
    logic [31:0] cfg_q;
    logic        wr_gw, wr_cfg, zero_wr, accept, abort, frame_done;
    logic        launch, sample, slot_end;
    logic [15:0] rdata;

    assign wr_gw   = reg_wr && (reg_sel == 1'b0);
    assign wr_cfg  = reg_wr && (reg_sel == 1'b1);
    assign zero_wr = wr_gw && (reg_wdata == 32'd0);
    assign accept  = wr_gw && !gw_q.busy && reg_wdata[30];
    assign abort   = zero_wr && gw_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            gw_q  <= '0;
            cfg_q <= CFG_RST;
        end else begin
            if (zero_wr)
                gw_q <= '0;
            else if (wr_gw && !gw_q.busy)
                gw_q <= gw_t'(reg_wdata);
            else if (frame_done) begin
                gw_q.busy <= 1'b0;
                if (gw_q.op == OPC_READ)
                    gw_q.ad <= rdata;
            end
            if (wr_cfg && !gw_q.busy)
                cfg_q <= reg_wdata & CFG_MASK;
        end
    end

    assign gw_rdata  = gw_q;
    assign cfg_rdata = cfg_q;

    mgw_slot_timer #(.HALF_W(HALF_W), .OFF_W(OFF_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (gw_q.busy),
        .half     (cfg_q[HALF_LSB +: HALF_W]),
        .in_off   (cfg_q[IN_LSB +: OFF_W]),
        .out_off  (cfg_q[OUT_LSB +: OFF_W]),
        .mdc      (mdc),
        .launch   (launch),
        .sample   (sample),
        .slot_end (slot_end)
    );

    mgw_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .frame_in (build_frame(gw_t'(reg_wdata))),
        .is_read  (reg_wdata[27:26] == OPC_READ),
        .run      (gw_q.busy),
        .stop     (abort),
        .launch   (launch),
        .sample   (sample),
        .slot_end (slot_end),
        .mdio_i   (mdio_in),
        .mdio_o   (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (frame_done),
        .rdata    (rdata)
    );

    // R4: busy only drops at frame end or on an abort
    a_r4_busy_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(gw_q.busy) |-> $past(frame_done || abort));

    // R7: command fields frozen while a frame runs
    a_r7_gw_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(gw_q.busy) && gw_q.busy) |->
        $stable({gw_q.lock, gw_q.op, gw_q.phy, gw_q.reg_a, gw_q.ad}));

    // R7: configuration frozen while a frame runs
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(gw_q.busy) |-> $stable(cfg_q));

    // R5: lock moves only on a software write
    a_r5_lock_sw_only: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_gw) |-> $stable(gw_q.lock));

endmodule

// File: tb/mgmt_mdio_gw_bench.sv
`timescale 1ns/1ps
module mgmt_mdio_gw_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] gw_rdata, cfg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b0;

    always #5 clk = ~clk;

    mgmt_mdio_gw u_mgmt_mdio_gw (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .gw_rdata(gw_rdata), .cfg_rdata(cfg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bus monitor: what the PHY sees at each MDC rise
    int          rises = 0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    always @(posedge mdc) begin
        cap   = {cap[62:0], mdio_out};
        oecap = {oecap[62:0], mdio_oe};
        rises++;
    end

    localparam logic [31:0] VEC_W [5] = '{
        32'hD401_1234, 32'hD841_0000, 32'hD7FF_FFFF, 32'hDBE0_0000, 32'hD625_0000 };
    localparam logic [15:0] VEC_D [5] = '{
        16'h0000, 16'hA5C3, 16'h0000, 16'h8001, 16'h0000 };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (gw_rdata[30] === 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] w);
        return {32'hFFFF_FFFF, 2'b01, w[27:26], w[20:16], w[25:21], 2'b10, w[15:0]};
    endfunction

    // PHY side: drive data bits k core edges after each MDC fall
    task automatic phy_drive(input logic [15:0] d, input int m, input int base);
        wait (rises == base + 48);
        for (int k = 0; k < 16; k++) begin
            @(negedge mdc);
            repeat (m) @(posedge clk);
            #1 mdio_in = d[15-k];
        end
    endtask

    task automatic run_read(input logic [31:0] w, input logic [15:0] d, input int m);
        int base;
        base = rises;
        mdio_in = 1'b0;
        fork
            phy_drive(d, m, base);
            begin
                wr(1'b0, w);
                wait_idle();
            end
        join
    endtask

    // cycles from an MDC rise to the start-bit zero on MDIO
    task automatic launch_delay(input logic [31:0] w, output int n);
        int base;
        base = rises;
        n = 0;
        fork
            begin
                wr(1'b0, w);
                wait_idle();
            end
            begin
                wait (rises == base + 32);
                while (mdio_out !== 1'b0 && n < 100) begin
                    @(posedge clk); #1;
                    n++;
                end
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base, n, hi, lo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 gateway", gw_rdata, 0);
        chk("R1 config", cfg_rdata, 32'h000D_613D);
        chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

        // R2/R3/R4 vector table
        for (int i = 0; i < 5; i++) begin
            logic [31:0] w;
            w = VEC_W[i];
            base = rises;
            if (w[27:26] == 2'b10) begin
                fork
                    run_read(w, VEC_D[i], 0);
                    begin @(negedge clk); @(negedge clk); chk("R4 busy set", gw_rdata[30], 1); end
                join
                chk("R2 read header", cap[63:18], exp_frame(w) >> 18);
                chk("R3 oe pattern", oecap, {{46{1'b1}}, 18'd0});
                chk("R3 readback", gw_rdata, (w & 32'hBFFF_0000) | VEC_D[i]);
            end else begin
                wr(1'b0, w);
                chk("R4 busy set", gw_rdata[30], 1);
                wait_idle();
                chk("R2 write frame", cap, exp_frame(w));
                chk("R2 oe pattern", oecap, {64{1'b1}});
                chk("R4 write done", gw_rdata, w & 32'hBFFF_FFFF);
            end
            chk("R4 edge count", rises - base, 64);
        end

        // R4 idle: MDC quiet
        base = rises;
        repeat (100) @(negedge clk);
        chk("R4 idle no edges", {rises - base, mdc}, 0);

        // R8 lock only, then R5 release
        base = rises;
        wr(1'b0, 32'h8000_0000);
        repeat (100) @(negedge clk);
        chk("R8 stored no frame", {gw_rdata, 32'(rises - base)}, {32'h8000_0000, 32'd0});
        wr(1'b0, 32'h0000_0000);
        repeat (100) @(negedge clk);
        chk("R5 zero write idle", {gw_rdata, 32'(rises - base)}, 0);

        // R7 writes ignored while busy
        base = rises;
        wr(1'b0, 32'hD401_1234);
        wait (rises == base + 5);
        wr(1'b0, 32'hC800_0000);
        wr(1'b1, 32'h0000_0000);
        chk("R7 gateway held", gw_rdata, 32'hD401_1234);
        chk("R7 config held", cfg_rdata, 32'h000D_613D);
        wait_idle();
        chk("R7 frame intact", cap, exp_frame(32'hD401_1234));

        // R6 abort
        base = rises;
        wr(1'b0, 32'hD625_0000);
        wait (rises == base + 10);
        wr(1'b0, 32'h0000_0000);
        chk("R6 busy/oe after abort", {gw_rdata, 31'd0, mdio_oe}, 0);
        @(negedge clk);
        chk("R6 mdc low", mdc, 0);
        base = rises;
        repeat (200) @(negedge clk);
        chk("R6 no edges after abort", rises - base, 0);

        // R10 input sample boundary (H=19, N=6)
        run_read(32'hD841_0000, 16'hA5C3, 13);
        chk("R10 late edge captured", gw_rdata[15:0], 16'hA5C3);
        run_read(32'hD841_0000, 16'hA5C3, 14);
        chk("R10 too late shifts", gw_rdata[15:0], 16'h52E1);

        // R11 launch offset default 13
        launch_delay(32'hD401_1234, n);
        chk("R11 launch delay", n, 13);

        // R9 half-period with H=4
        wr(1'b1, 32'h0003_204D);
        chk("R9 config written", cfg_rdata, 32'h0003_204D);
        base = rises;
        hi = 0; lo = 0;
        fork
            begin wr(1'b0, 32'hD401_1234); wait_idle(); end
            begin
                wait (rises == base + 10);
                while (mdc !== 1'b0 && hi < 50) begin @(posedge clk); #1; hi++; end
                while (mdc !== 1'b1 && lo < 50) begin @(posedge clk); #1; lo++; end
            end
        join
        chk("R9 high time", hi, 5);
        chk("R9 low time", lo, 5);
        chk("R9 frame", cap, exp_frame(32'hD401_1234));

        // R12 clamp: H=9, N=15, M=15
        wr(1'b1, 32'h000F_F09D);
        launch_delay(32'hD401_1234, n);
        chk("R12 out clamp", n, 10);
        chk("R12 frame", cap, exp_frame(32'hD401_1234));
        run_read(32'hDBE0_0000, 16'h8001, 0);
        chk("R12 in clamp", gw_rdata, 32'h9BE0_8001);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule